// File: doc/BRIEF.md
# I2C Interrupt Status Unit

This block collects four interrupt conditions for an I2C controller and holds each one in a sticky status flag. Each flag drives its own interrupt output with no extra logic in between. The four flags are:

- **Transfer-engine completion.** A one-cycle pulse from the engine, sent when it finishes a transaction and drops its run bit.
- **Bus-free.** Raised when a STOP appears on the bus after this controller has lost arbitration, so the master can retry.
- **Read-queue fill.** Raised when the read FIFO level reaches or exceeds its threshold.
- **Write-queue drain.** Raised when the write FIFO level falls to or below its threshold.

The unit samples SCL and SDA through a synchronizer. It finds START and STOP conditions on the synchronized lines and uses them to track a bus-busy state.

Software works with the unit through two threshold-load strobes that share one data bus, and a write-one-to-clear mask. A flag set condition has priority over a clear in the same cycle, so no event is lost. The two FIFO flags set on the edge of their condition: once cleared, a flag stays low until its level condition has gone false and then become true again.

Top module: `i2c_irq_status`

## Requirements
- R1: While reset is asserted and immediately after it, all four interrupt outputs and `bus_busy` are 0.
- R2: A one-cycle `engine_done` pulse sets `irq_engine_done` at the next rising clock edge, and the flag stays set until cleared.
- R3: After an `arb_lost` pulse, the next STOP sets `irq_bus_free`. That same STOP consumes the lost-arbitration record, so a later STOP without a new `arb_lost` pulse does not set the flag again.
- R4: A STOP seen while no arbitration loss is recorded leaves `irq_bus_free` low.
- R5: `irq_rd_queue` sets in the cycle after `rd_level >= rd_threshold` becomes true (unsigned compare).
- R6: `irq_wr_queue` sets in the cycle after `wr_level <= wr_threshold` becomes true (unsigned compare).
- R7: After a FIFO flag is cleared while its condition still holds, it stays low until the condition has been false for at least one cycle and then becomes true again.
- R8: `clr_mask` is write-one-to-clear and sampled each cycle. Bit 0 clears engine-done, bit 1 clears bus-free, bit 2 clears read-queue and bit 3 clears write-queue. When a set and a clear of the same flag meet in one cycle, the flag ends up set.
- R9: A START (SDA falling while SCL stays high) sets `bus_busy`, and a STOP (SDA rising while SCL stays high) clears it. Both are judged on the lines after the synchronizer, so `bus_busy` responds by the third rising edge after the line change.
- R10: SDA transitions while SCL is low do not change `bus_busy`.
- R11: A pulse on `rd_thr_load` or `wr_thr_load` loads `thr_data` into that threshold. The reset values are 16 for the read threshold and 0 for the write threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| engine_done | input | 1 | Transfer-engine completion pulse |
| arb_lost | input | 1 | Arbitration-lost pulse |
| rd_level | input | 5 | Read FIFO fill level |
| wr_level | input | 5 | Write FIFO fill level |
| rd_thr_load | input | 1 | Load strobe for the read threshold |
| wr_thr_load | input | 1 | Load strobe for the write threshold |
| thr_data | input | 5 | Threshold value to load |
| clr_mask | input | 4 | Write-one-to-clear strobes for the four flags |
| irq_engine_done | output | 1 | Engine-completion interrupt |
| irq_bus_free | output | 1 | Bus-free interrupt |
| irq_rd_queue | output | 1 | Read-queue threshold interrupt |
| irq_wr_queue | output | 1 | Write-queue threshold interrupt |
| bus_busy | output | 1 | Bus-busy state |

## Verification
Two pairs of events can land in the same cycle and must be judged together.

- **Set meets clear.** The bench drives `engine_done` together with its clear bit, and a rising write-queue condition together with its clear bit. It expects the flag to read 1 one cycle later.
- **Arbitration loss meets STOP.** The bench gives an `arb_lost` pulse and then a STOP, and checks that `irq_bus_free` rises. It then sends a second START/STOP pair without a new `arb_lost` pulse, and checks that the flag stays low after being cleared.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
   // bit positions inside the clear mask
   localparam int unsigned IRQ_COUNT = 4;
   typedef enum logic [1:0] {
      IRQ_ENGINE = 2'd0,
      IRQ_FREE   = 2'd1,
      IRQ_RDQ    = 2'd2,
      IRQ_WRQ    = 2'd3
   } irq_idx_e;

   typedef struct packed {
      logic start;
      logic stop;
   } bus_event_t;
endpackage

// File: rtl/i2c_irq_flag.sv
module i2c_irq_flag #(
   parameter bit EDGE_SET = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cond,
   input  logic clr,
   output logic flag
);
   logic set_ev;
   logic flag_q;

   generate
      if (EDGE_SET) begin : g_edge
         logic cond_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cond_q <= 1'b0;
            else        cond_q <= cond;
         end
         assign set_ev = cond & ~cond_q;
      end else begin : g_level
         assign set_ev = cond;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= set_ev | (flag_q & ~clr);
   end

   assign flag = flag_q;

   // R8: a set event wins over a same-cycle clear
   a_r8_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
      set_ev |=> flag);
   a_r8_clear_drops : assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set_ev) |=> !flag);
   a_r8_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
   import i2c_irq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_in,
   input  logic       sda_in,
   output bus_event_t ev,
   output logic       busy
);
   localparam int unsigned LAST = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [LAST:0] scl_sh, sda_sh;
   logic          scl_prev, sda_prev;
   logic          scl_s, sda_s;
   logic          busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh   <= '1;
         sda_sh   <= '1;
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_sh   <= {scl_sh[LAST-1:0], scl_in};
         sda_sh   <= {sda_sh[LAST-1:0], sda_in};
         scl_prev <= scl_sh[LAST];
         sda_prev <= sda_sh[LAST];
      end
   end

   assign scl_s = scl_sh[LAST];
   assign sda_s = sda_sh[LAST];

   always_comb begin
      ev.start = scl_s & scl_prev & sda_prev & ~sda_s;
      ev.stop  = scl_s & scl_prev & ~sda_prev & sda_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        busy_q <= 1'b0;
      else if (ev.start) busy_q <= 1'b1;
      else if (ev.stop)  busy_q <= 1'b0;
   end

   assign busy = busy_q;

   // R9: START marks the bus busy, STOP releases it
   a_r9_start_busy : assert property (@(posedge clk) disable iff (!rst_n)
      ev.start |=> busy);
   a_r9_stop_idle : assert property (@(posedge clk) disable iff (!rst_n)
      ev.stop |=> !busy);
   // R10: no busy change while synchronized SCL was low
   a_r10_scl_low : assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_prev || !scl_s) |=> $stable(busy));
   a_r9_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
      !(ev.start && ev.stop));
endmodule

// File: rtl/i2c_queue_watch.sv
module i2c_queue_watch #(
   parameter int unsigned LEVEL_W  = 5,
   parameter bit          AT_ABOVE = 1'b1,
   parameter int unsigned THR_INIT = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LEVEL_W-1:0] level,
   input  logic               thr_load,
   input  logic [LEVEL_W-1:0] thr_data,
   input  logic               clr,
   output logic               flag
);
   localparam logic [LEVEL_W-1:0] THR_RST = LEVEL_W'(THR_INIT);

   generate
      if (LEVEL_W < 1) begin : g_bad_w
         $error("LEVEL_W must be at least 1");
      end
      if (THR_INIT >= (1 << LEVEL_W)) begin : g_bad_init
         $error("THR_INIT does not fit LEVEL_W");
      end
   endgenerate

   logic [LEVEL_W-1:0] thr_q;
   logic               hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        thr_q <= THR_RST;
      else if (thr_load) thr_q <= thr_data;
   end

   generate
      if (AT_ABOVE) begin : g_fill
         assign hit = (level >= thr_q);
      end else begin : g_drain
         assign hit = (level <= thr_q);
      end
   endgenerate

   i2c_irq_flag #(.EDGE_SET(1'b1)) u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .cond  (hit),
      .clr   (clr),
      .flag  (flag)
   );

   // R11: a load strobe is visible in the threshold one cycle later
   a_r11_thr_load : assert property (@(posedge clk) disable iff (!rst_n)
      thr_load |=> (thr_q == $past(thr_data)));
   a_r11_thr_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !thr_load |=> $stable(thr_q));
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
   import i2c_irq_pkg::*;
#(
   parameter int unsigned LEVEL_W      = 5,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned RD_THR_INIT  = 16,
   parameter int unsigned WR_THR_INIT  = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_in,
   input  logic               sda_in,
   input  logic               engine_done,
   input  logic               arb_lost,
   input  logic [LEVEL_W-1:0] rd_level,
   input  logic [LEVEL_W-1:0] wr_level,
   input  logic               rd_thr_load,
   input  logic               wr_thr_load,
   input  logic [LEVEL_W-1:0] thr_data,
   input  logic [3:0]         clr_mask,
   output logic               irq_engine_done,
   output logic               irq_bus_free,
   output logic               irq_rd_queue,
   output logic               irq_wr_queue,
   output logic               bus_busy
);
   generate
      if (IRQ_COUNT != 4) begin : g_bad_count
         $error("clear mask width does not match flag count");
      end
   endgenerate

   bus_event_t ev;
   logic       arb_q;
   logic       free_set;

   i2c_bus_watch #(.SYNC_STAGES(SYNC_STAGES)) u_watch (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_in(scl_in),
      .sda_in(sda_in),
      .ev    (ev),
      .busy  (bus_busy)
   );

   assign free_set = ev.stop & arb_q;

   // lost-arbitration record, consumed by the STOP that frees the bus
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) arb_q <= 1'b0;
      else        arb_q <= arb_lost | (arb_q & ~free_set);
   end

   i2c_irq_flag #(.EDGE_SET(1'b0)) u_done (
      .clk   (clk),
      .rst_n (rst_n),
      .cond  (engine_done),
      .clr   (clr_mask[IRQ_ENGINE]),
      .flag  (irq_engine_done)
   );

   i2c_irq_flag #(.EDGE_SET(1'b0)) u_free (
      .clk   (clk),
      .rst_n (rst_n),
      .cond  (free_set),
      .clr   (clr_mask[IRQ_FREE]),
      .flag  (irq_bus_free)
   );

   i2c_queue_watch #(.LEVEL_W(LEVEL_W), .AT_ABOVE(1'b1), .THR_INIT(RD_THR_INIT)) u_rdq (
      .clk      (clk),
      .rst_n    (rst_n),
      .level    (rd_level),
      .thr_load (rd_thr_load),
      .thr_data (thr_data),
      .clr      (clr_mask[IRQ_RDQ]),
      .flag     (irq_rd_queue)
   );

   i2c_queue_watch #(.LEVEL_W(LEVEL_W), .AT_ABOVE(1'b0), .THR_INIT(WR_THR_INIT)) u_wrq (
      .clk      (clk),
      .rst_n    (rst_n),
      .level    (wr_level),
      .thr_load (wr_thr_load),
      .thr_data (thr_data),
      .clr      (clr_mask[IRQ_WRQ]),
      .flag     (irq_wr_queue)
   );

   // R3: STOP with a recorded loss frees the bus and consumes the record
   a_r3_free_on_stop : assert property (@(posedge clk) disable iff (!rst_n)
      (ev.stop && arb_q && !arb_lost) |=> (irq_bus_free && !arb_q));
   // R4: bus-free only ever rises out of a recorded loss
   a_r4_needs_arb : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_bus_free) |-> $past(arb_q));
   // R2: completion pulse reaches the interrupt output next cycle
   a_r2_done_irq : assert property (@(posedge clk) disable iff (!rst_n)
      engine_done |=> irq_engine_done);
endmodule

// File: tb/i2c_irq_status_test.sv
module i2c_irq_status_test;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_in = 1'b1, sda_in = 1'b1;
   logic       engine_done = 1'b0, arb_lost = 1'b0;
   logic [4:0] rd_level = 5'd0, wr_level = 5'd31;
   logic       rd_thr_load = 1'b0, wr_thr_load = 1'b0;
   logic [4:0] thr_data = 5'd0;
   logic [3:0] clr_mask = 4'd0;
   logic       irq_engine_done, irq_bus_free, irq_rd_queue, irq_wr_queue, bus_busy;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_irq_status uut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .engine_done(engine_done), .arb_lost(arb_lost),
      .rd_level(rd_level), .wr_level(wr_level),
      .rd_thr_load(rd_thr_load), .wr_thr_load(wr_thr_load), .thr_data(thr_data),
      .clr_mask(clr_mask),
      .irq_engine_done(irq_engine_done), .irq_bus_free(irq_bus_free),
      .irq_rd_queue(irq_rd_queue), .irq_wr_queue(irq_wr_queue), .bus_busy(bus_busy)
   );

   // {rd_level, wr_level, clr_rd, clr_wr, exp_rd, exp_wr}; rd thr 8, wr thr 4
   localparam int NVEC = 10;
   localparam logic [13:0] VEC [NVEC] = '{
      {5'd7,  5'd5,  2'b00, 2'b00},
      {5'd8,  5'd5,  2'b00, 2'b10},
      {5'd9,  5'd4,  2'b00, 2'b11},
      {5'd9,  5'd4,  2'b11, 2'b00},
      {5'd12, 5'd0,  2'b00, 2'b00},
      {5'd3,  5'd10, 2'b00, 2'b00},
      {5'd16, 5'd2,  2'b00, 2'b11},
      {5'd0,  5'd31, 2'b11, 2'b00},
      {5'd8,  5'd4,  2'b01, 2'b11},
      {5'd8,  5'd4,  2'b00, 2'b11}
   };

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      cyc(3);
      // R1: reset state while reset held
      chk("R1 engine", irq_engine_done, 1'b0);
      chk("R1 free", irq_bus_free, 1'b0);
      chk("R1 rdq", irq_rd_queue, 1'b0);
      chk("R1 wrq", irq_wr_queue, 1'b0);
      chk("R1 busy", bus_busy, 1'b0);
      rst_n = 1'b1;
      cyc(2);
      // R11: reset thresholds 16 and 0: level 0 < 16, level 31 > 0
      chk("R11 rd thr reset", irq_rd_queue, 1'b0);
      rd_level = 5'd16;
      cyc(1);
      chk("R11 rd thr reset 16", irq_rd_queue, 1'b1);
      rd_level = 5'd0;
      wr_level = 5'd0;
      cyc(1);
      chk("R11 wr thr reset 0", irq_wr_queue, 1'b1);
      wr_level = 5'd31;
      clr_mask = 4'b1100;
      cyc(1);
      clr_mask = 4'b0000;
      // R11: load thresholds
      thr_data = 5'd8; rd_thr_load = 1'b1; cyc(1); rd_thr_load = 1'b0;
      thr_data = 5'd4; wr_thr_load = 1'b1; cyc(1); wr_thr_load = 1'b0;
      cyc(1);
      chk("R11 rdq idle", irq_rd_queue, 1'b0);
      chk("R11 wrq idle", irq_wr_queue, 1'b0);

      // R5 R6 R7 R8: vector walk
      for (int v = 0; v < NVEC; v++) begin
         rd_level = VEC[v][13:9];
         wr_level = VEC[v][8:4];
         clr_mask = {VEC[v][2], VEC[v][3], 2'b00};
         cyc(1);
         chk($sformatf("R5/R7 rdq vec %0d", v), irq_rd_queue, VEC[v][1]);
         chk($sformatf("R6/R8 wrq vec %0d", v), irq_wr_queue, VEC[v][0]);
      end
      clr_mask = 4'b0000;

      // R2: completion pulse
      engine_done = 1'b1; cyc(1); engine_done = 1'b0;
      chk("R2 set", irq_engine_done, 1'b1);
      cyc(3);
      chk("R2 held", irq_engine_done, 1'b1);
      clr_mask = 4'b0001; cyc(1); clr_mask = 4'b0000;
      chk("R8 clear engine", irq_engine_done, 1'b0);
      engine_done = 1'b1; clr_mask = 4'b0001; cyc(1);
      engine_done = 1'b0; clr_mask = 4'b0000;
      chk("R8 set wins engine", irq_engine_done, 1'b1);
      clr_mask = 4'b0001; cyc(1); clr_mask = 4'b0000;

      // R9: START then STOP
      sda_in = 1'b0; cyc(4);
      chk("R9 start busy", bus_busy, 1'b1);
      // R10: SDA toggles with SCL low
      scl_in = 1'b0; cyc(2);
      sda_in = 1'b1; cyc(2);
      sda_in = 1'b0; cyc(2);
      scl_in = 1'b1; cyc(4);
      chk("R10 busy kept", bus_busy, 1'b1);
      // R4: STOP without arbitration loss
      sda_in = 1'b1; cyc(4);
      chk("R9 stop idle", bus_busy, 1'b0);
      chk("R4 no free", irq_bus_free, 1'b0);

      // R3: arbitration lost then STOP
      arb_lost = 1'b1; cyc(1); arb_lost = 1'b0;
      sda_in = 1'b0; cyc(4);
      chk("R3 no free on start", irq_bus_free, 1'b0);
      sda_in = 1'b1; cyc(4);
      chk("R3 free on stop", irq_bus_free, 1'b1);
      clr_mask = 4'b0010; cyc(1); clr_mask = 4'b0000;
      chk("R8 clear free", irq_bus_free, 1'b0);
      // R3: record consumed, second STOP does nothing
      sda_in = 1'b0; cyc(4);
      sda_in = 1'b1; cyc(4);
      chk("R3 record consumed", irq_bus_free, 1'b0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule